// File: doc/BRIEF.md
# Saturating Up/Down Trim Counter

This block keeps a 5-bit code that trims a bias-voltage DAC. Two push-button-style logic inputs step the code one position per rising edge. The inputs are asynchronous to the block, so each one passes through a two-flop synchroniser before edge detection. The count saturates at both ends and never wraps. It returns to mid-scale (binary 10000) after reset, and also whenever both step inputs are high at the same time.

A polarity input swaps the meaning of the two step inputs, so that each button keeps the same effect on the magnitude of the output for positive and for negative supplies. With positive polarity a lower code raises the output, so the "raise" input decrements the code. An active-low shutdown input freezes the stored code and ignores all step activity. While shutdown is asserted, the DAC drive code is forced to zero. The undervoltage condition of the supply reaches this block as the asynchronous reset.

Top module: `trim_updn_ctrl`

## Requirements
- R1: After reset the stored code `code_o` is 16 (binary 10000, mid-scale).
- R2: With `pol_i` high, each rising edge of `up_i` lowers `code_o` by one and each rising edge of `dn_i` raises it by one.
- R3: With `pol_i` low, each rising edge of `up_i` raises `code_o` by one and each rising edge of `dn_i` lowers it by one.
- R4: A decrement requested at code 0 leaves the code at 0.
- R5: An increment requested at code 31 leaves the code at 31.
- R6: While `up_i` and `dn_i` are both high, the code is reloaded with 16. A rising edge that completes this both-high condition does not also step the code.
- R7: While `shdn_ni` is low, edges and the both-high condition on `up_i`/`dn_i` leave `code_o` unchanged.
- R8: `dac_code_o` is 0 while `shdn_ni` is low and equals `code_o` while `shdn_ni` is high. Both are observed once the synchroniser latency has passed.
- R9: An input held high steps the code only once, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than 1 MHz |
| rst_ni | input | 1 | Active-low asynchronous reset (undervoltage or power-up) |
| up_i | input | 1 | Asynchronous step input "up" |
| dn_i | input | 1 | Asynchronous step input "down" |
| pol_i | input | 1 | Output polarity: 1 positive, 0 negative |
| shdn_ni | input | 1 | Active-low shutdown |
| code_o | output | 5 | Stored trim code |
| dac_code_o | output | 5 | DAC drive code, zero in shutdown |

## Verification
A step edge and the mid-scale reload can fall in the same cycle. This happens when one input is already high and the other rises, which completes the both-high condition with that edge. The bench provokes this from a code away from mid-scale: it holds one input high, raises the other, and requires exactly 16 rather than 16 plus or minus one. It also raises both inputs together and requires the same result. Shutdown meeting a step edge is provoked by pulsing each input while shutdown is low, and is judged by an unchanged `code_o` with `dac_code_o` held at zero.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_MID  = 2'd3
  } step_cmd_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/trim_edge.sv
module trim_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/trim_step_ctl.sv
module trim_step_ctl
  import trim_pkg::*;
(
  input  logic      run_i,
  input  logic      pol_i,
  input  logic      up_lvl_i,
  input  logic      dn_lvl_i,
  input  logic      up_rise_i,
  input  logic      dn_rise_i,
  output step_cmd_e cmd_o
);
  // both-high outranks any edge in the same cycle
  always_comb begin
    cmd_o = STEP_NONE;
    if (run_i) begin
      if (up_lvl_i && dn_lvl_i) cmd_o = STEP_MID;
      else if (up_rise_i)       cmd_o = pol_i ? STEP_DEC : STEP_INC;
      else if (dn_rise_i)       cmd_o = pol_i ? STEP_INC : STEP_DEC;
    end
  end
endmodule

// File: rtl/trim_counter.sv
module trim_counter
  import trim_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_cmd_e         cmd_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP_CODE = '1;

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    unique case (cmd_i)
      STEP_INC:  if (code_q != TOP_CODE) code_d = code_q + CODE_W'(1);
      STEP_DEC:  if (code_q != '0)       code_d = code_q - CODE_W'(1);
      STEP_MID:  code_d = MID_CODE;
      default:   code_d = code_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= MID_CODE;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/trim_updn_ctrl.sv
module trim_updn_ctrl
  import trim_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              pol_i,
  input  logic              shdn_ni,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] dac_code_o
);
  localparam int N_IN  = 4;
  localparam int IX_UP = 0;
  localparam int IX_DN = 1;
  localparam int IX_SD = 2;
  localparam int IX_PO = 3;

  logic [N_IN-1:0] raw_in, sync_in;
  logic [1:0]      rise;
  logic            run, both_hi;
  step_cmd_e       step_cmd;

  assign raw_in = {pol_i, shdn_ni, dn_i, up_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    trim_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in[i]),
      .q_o   (sync_in[i])
    );
  end

  for (genvar i = 0; i < 2; i++) begin : g_edge
    trim_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (sync_in[i]),
      .rise_o(rise[i])
    );
  end

  assign run     = sync_in[IX_SD];
  assign both_hi = sync_in[IX_UP] & sync_in[IX_DN];

  trim_step_ctl u_step (
    .run_i    (run),
    .pol_i    (sync_in[IX_PO]),
    .up_lvl_i (sync_in[IX_UP]),
    .dn_lvl_i (sync_in[IX_DN]),
    .up_rise_i(rise[IX_UP]),
    .dn_rise_i(rise[IX_DN]),
    .cmd_o    (step_cmd)
  );

  trim_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (step_cmd),
    .code_o(code_o)
  );

  assign dac_code_o = run ? code_o : '0;
endmodule

// File: rtl/trim_updn_chk.sv
module trim_updn_chk
  import trim_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_o,
  input logic [CODE_W-1:0] dac_code_o,
  input step_cmd_e         step_cmd,
  input logic              run,
  input logic              both_hi
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP_CODE = '1;

  // R2
  step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |->
      (code_o == MID_CODE || code_o == $past(code_o) + CODE_W'(1) ||
       code_o + CODE_W'(1) == $past(code_o)));

  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == '0 && step_cmd == STEP_DEC) |=> code_o == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == TOP_CODE && step_cmd == STEP_INC) |=> code_o == TOP_CODE);

  // R6
  mid_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && both_hi) |=> code_o == MID_CODE);

  // R7
  shdn_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(code_o));

  // R8
  dac_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o != '0) |-> (dac_code_o == code_o && run));
endmodule

bind trim_updn_ctrl trim_updn_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_o    (code_o),
  .dac_code_o(dac_code_o),
  .step_cmd  (step_cmd),
  .run       (run),
  .both_hi   (both_hi)
);

// File: tb/tb_trim_updn_ctrl.sv
`timescale 1ns/1ps
module tb_trim_updn_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up_i = 1'b0, dn_i = 1'b0, pol_i = 1'b1, shdn_ni = 1'b1;
  logic [4:0] code_o, dac_code_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  trim_updn_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(up_i), .dn_i(dn_i),
    .pol_i(pol_i), .shdn_ni(shdn_ni), .code_o(code_o), .dac_code_o(dac_code_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  task automatic pulse_up();
    up_i = 1'b1; settle(); up_i = 1'b0; settle();
  endtask

  task automatic pulse_dn();
    dn_i = 1'b1; settle(); dn_i = 1'b0; settle();
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 code after reset", code_o, 16);
    rst_ni = 1'b1;
    settle();
    check("R1 code idle", code_o, 16);
    check("R8 dac follows code", dac_code_o, 16);
  endtask

  task automatic t_pos_steps();
    pol_i = 1'b1; settle();
    pulse_up();
    check("R2 up decrements", code_o, 15);
    pulse_dn(); pulse_dn();
    check("R2 dn increments", code_o, 17);
  endtask

  task automatic t_hold();
    up_i = 1'b1;
    repeat (30) @(negedge clk_i);
    check("R9 held up one step", code_o, 16);
    up_i = 1'b0; settle();
    check("R9 release no step", code_o, 16);
  endtask

  task automatic t_neg_steps();
    pol_i = 1'b0; settle();
    pulse_up();
    check("R3 up increments", code_o, 17);
    pulse_dn(); pulse_dn();
    check("R3 dn decrements", code_o, 15);
    pol_i = 1'b1; settle();
  endtask

  task automatic t_floor();
    for (int i = 0; i < 20; i++) pulse_up();
    check("R4 floor reached", code_o, 0);
    pulse_up();
    check("R4 hold at zero", code_o, 0);
  endtask

  task automatic t_ceiling();
    for (int i = 0; i < 35; i++) pulse_dn();
    check("R5 ceiling reached", code_o, 31);
    pulse_dn();
    check("R5 hold at top", code_o, 31);
  endtask

  task automatic t_both();
    up_i = 1'b1; settle();
    check("R2 step before both", code_o, 30);
    dn_i = 1'b1; settle();
    check("R6 completing edge reloads mid", code_o, 16);
    repeat (10) @(negedge clk_i);
    check("R6 held both stays mid", code_o, 16);
    up_i = 1'b0; settle();
    check("R6 release one no step", code_o, 16);
    dn_i = 1'b0; settle();
    pulse_dn(); pulse_dn();
    check("R2 setup 18", code_o, 18);
    up_i = 1'b1; dn_i = 1'b1; settle();
    check("R6 simultaneous rise", code_o, 16);
    up_i = 1'b0; dn_i = 1'b0; settle();
    check("R6 after release", code_o, 16);
  endtask

  task automatic t_shutdown();
    pulse_up(); pulse_up();
    check("R2 setup 14", code_o, 14);
    shdn_ni = 1'b0; settle();
    check("R8 dac zero in shutdown", dac_code_o, 0);
    check("R7 code kept", code_o, 14);
    pulse_up(); pulse_dn();
    check("R7 edges ignored", code_o, 14);
    up_i = 1'b1; dn_i = 1'b1; settle();
    check("R7 both-high ignored", code_o, 14);
    check("R8 dac still zero", dac_code_o, 0);
    up_i = 1'b0; dn_i = 1'b0; settle();
    shdn_ni = 1'b1; settle();
    check("R8 dac restored", dac_code_o, 14);
    check("R7 code after resume", code_o, 14);
  endtask

  initial begin
    t_reset();
    t_pos_steps();
    t_hold();
    t_neg_steps();
    t_floor();
    t_ceiling();
    t_both();
    t_shutdown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule